// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block is the program-flow unit of a small 8-bit processor with a 16-bit program counter and a 16-bit stack pointer. It recognises the subroutine-control opcodes: direct call, conditional call, restart, direct return, conditional return, and the jump that loads the program counter from the H:L register pair. For each one it sequences the byte-wide stack traffic that saves or restores the return address. It then updates its program counter and stack pointer registers.

An instruction is launched by a one-cycle `start_i` pulse. The pulse carries the opcode, both immediate address bytes, the flag bits and the H and L values. The block then stays busy for the full state count of the instruction, where one clock is one state. Inside the busy window it drives byte-wide memory reads and writes. It pulses `done_o` in the last state. Operand fetch, the ALU, the register file and every other opcode belong to neighbouring blocks.

Top module: `subr_flow_unit`

## Requirements
- R1: The block accepts these opcodes when idle: 11001101 direct call, 11CCC100 conditional call, 11NNN111 restart, 11001001 return, 11CCC000 conditional return, and 11101001 pair jump. Any other opcode on `start_i` does not make the block busy and leaves `pc_o` and `sp_o` unchanged.
- R2: A taken call pushes the return address, which is the opcode address plus 3. The high byte is written first, to SP-1, and the low byte second, to SP-2. SP then drops by 2 and PC becomes {imm_hi_i, imm_lo_i}.
- R3: A restart pushes the opcode address plus 1 in the same way as a call. PC then becomes 8 × NNN, a value from 0x0000 to 0x0038.
- R4: A taken return reads the PC low byte from SP and then the PC high byte from SP+1. SP then rises by 2.
- R5: The pair jump sets PC to {reg_h_i, reg_l_i}. It makes no memory access and leaves SP unchanged.
- R6: The flag bit positions are carry [0], parity [1], zero [2] and sign [3]. The CCC field selects one flag: 00x zero, 01x carry, 10x parity, 11x sign. The condition is true when that flag equals CCC[0]. A false condition makes no memory access, leaves SP unchanged, and advances PC by 3 for a call or by 1 for a return.
- R7: The number of busy states is 17 for a direct call and for a taken conditional call, and 11 for an untaken conditional call. It is 11 for a restart, 10 for a return, 11 for a taken conditional return, 5 for an untaken conditional return, and 5 for the pair jump.
- R8: In an instruction of L states, each stack access has a one-cycle strobe. The first access falls in state L-4 and the second in state L-1. Read data is taken in the strobe cycle. `mem_rd_o` and `mem_wr_o` are never high together, and neither is high outside the busy window.
- R9: The stack pointer and every stack address wrap modulo 2^16.
- R10: `done_o` is high only in the last busy state. `pc_o` and `sp_o` change only on the clock edge that ends that state.
- R11: A `start_i` pulse that arrives while the block is busy is ignored. It does not change the current instruction's accesses, length or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one period is one state |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse; the operand inputs below are sampled with it |
| opcode_i | input | 8 | Opcode of the instruction being launched |
| imm_lo_i | input | 8 | Low target address byte (second instruction byte) |
| imm_hi_i | input | 8 | High target address byte (third instruction byte) |
| flags_i | input | 4 | Flags: carry [0], parity [1], zero [2], sign [3] |
| reg_h_i | input | 8 | H register value |
| reg_l_i | input | 8 | L register value |
| mem_rdata_i | input | 8 | Read data, valid in the `mem_rd_o` cycle |
| mem_addr_o | output | 16 | Stack address during a strobe |
| mem_wdata_o | output | 8 | Write data during `mem_wr_o` |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| busy_o | output | 1 | An instruction is in progress |
| done_o | output | 1 | Final state of the current instruction |
| pc_o | output | 16 | Program counter register |
| sp_o | output | 16 | Stack pointer register |

## Verification
The bench goes after stack-pointer wrap. It pushes from SP=0x0001 so the two writes land at 0x0000 and 0xFFFF, then pops them back. A design that carries past 16 bits or decrements in the wrong width would write to the wrong place and return to a wrong PC. Every condition code is tried with its own flag set and then cleared while all other flags hold the opposite value. A design with a swapped flag position or an inverted polarity would take the wrong branch, and the state count and stack traffic would show it. The bench also checks byte order and strobe placement against an independent model in every cycle. It injects a second launch in mid-instruction, which a design that re-arms while busy would obey.

// File: rtl/subr_flow_pkg.sv
package subr_flow_pkg;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int FLAG_W  = 4;
    localparam int CNT_W   = 5;

    // flag bit positions
    localparam int FL_CARRY  = 0;
    localparam int FL_PARITY = 1;
    localparam int FL_ZERO   = 2;
    localparam int FL_SIGN   = 3;

    // machine-cycle shape: memory cycles are MCYC_ST states, strobe in state MID_ST
    localparam int MCYC_ST   = 3;
    localparam int MID_ST    = 2;
    localparam int FETCH_LNG = 5;
    localparam int FETCH_SHT = 4;

    localparam logic [CNT_W-1:0] LEN_CALL   = CNT_W'(FETCH_LNG + 4 * MCYC_ST);
    localparam logic [CNT_W-1:0] LEN_CSKIP  = CNT_W'(FETCH_LNG + 2 * MCYC_ST);
    localparam logic [CNT_W-1:0] LEN_RST    = CNT_W'(FETCH_LNG + 2 * MCYC_ST);
    localparam logic [CNT_W-1:0] LEN_RET    = CNT_W'(FETCH_SHT + 2 * MCYC_ST);
    localparam logic [CNT_W-1:0] LEN_CRET   = CNT_W'(FETCH_LNG + 2 * MCYC_ST);
    localparam logic [CNT_W-1:0] LEN_SHORT  = CNT_W'(FETCH_LNG);

    typedef enum logic [2:0] {
        K_NONE,
        K_CALL,
        K_RST,
        K_RET,
        K_JUMP
    } flow_kind_e;

    typedef struct packed {
        flow_kind_e         kind;
        logic               taken;
        logic [CNT_W-1:0]   len;
        logic [1:0]         step;
        logic [ADDR_W-1:0]  target;
    } flow_dec_t;

endpackage

// File: rtl/subr_cond_eval.sv
module subr_cond_eval
    import subr_flow_pkg::*;
(
    input  logic [2:0]        ccc_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              hit_o
);

    logic sel_flag;

    always_comb begin
        case (ccc_i[2:1])
            2'd0:    sel_flag = flags_i[FL_ZERO];
            2'd1:    sel_flag = flags_i[FL_CARRY];
            2'd2:    sel_flag = flags_i[FL_PARITY];
            default: sel_flag = flags_i[FL_SIGN];
        endcase
        hit_o = (sel_flag == ccc_i[0]);
    end

endmodule

// File: rtl/subr_op_decode.sv
module subr_op_decode
    import subr_flow_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode_i,
    input  logic [BYTE_W-1:0] imm_lo_i,
    input  logic [BYTE_W-1:0] imm_hi_i,
    input  logic [BYTE_W-1:0] reg_h_i,
    input  logic [BYTE_W-1:0] reg_l_i,
    input  logic [FLAG_W-1:0] flags_i,
    output flow_dec_t         dec_o
);

    logic cond_hit;
    logic top_pair;

    subr_cond_eval u_cond (
        .ccc_i   (opcode_i[5:3]),
        .flags_i (flags_i),
        .hit_o   (cond_hit)
    );

    assign top_pair = (opcode_i[7:6] == 2'b11);

    always_comb begin
        dec_o.kind   = K_NONE;
        dec_o.taken  = 1'b0;
        dec_o.len    = '0;
        dec_o.step   = 2'd1;
        dec_o.target = '0;
        if (top_pair) begin
            case (opcode_i[2:0])
                3'b100: begin
                    dec_o.kind   = K_CALL;
                    dec_o.taken  = cond_hit;
                    dec_o.len    = cond_hit ? LEN_CALL : LEN_CSKIP;
                    dec_o.step   = 2'd3;
                    dec_o.target = {imm_hi_i, imm_lo_i};
                end
                3'b101: begin
                    if (opcode_i[5:3] == 3'b001) begin
                        dec_o.kind   = K_CALL;
                        dec_o.taken  = 1'b1;
                        dec_o.len    = LEN_CALL;
                        dec_o.step   = 2'd3;
                        dec_o.target = {imm_hi_i, imm_lo_i};
                    end
                end
                3'b111: begin
                    dec_o.kind   = K_RST;
                    dec_o.taken  = 1'b1;
                    dec_o.len    = LEN_RST;
                    dec_o.target = ADDR_W'({opcode_i[5:3], 3'b000});
                end
                3'b000: begin
                    dec_o.kind   = K_RET;
                    dec_o.taken  = cond_hit;
                    dec_o.len    = cond_hit ? LEN_CRET : LEN_SHORT;
                end
                3'b001: begin
                    if (opcode_i[5:3] == 3'b001) begin
                        dec_o.kind  = K_RET;
                        dec_o.taken = 1'b1;
                        dec_o.len   = LEN_RET;
                    end else if (opcode_i[5:3] == 3'b101) begin
                        dec_o.kind   = K_JUMP;
                        dec_o.taken  = 1'b1;
                        dec_o.len    = LEN_SHORT;
                        dec_o.target = {reg_h_i, reg_l_i};
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/subr_slot_timer.sv
module subr_slot_timer #(
    parameter int CW   = 5,
    parameter int MCYC = 3,
    parameter int MID  = 2
) (
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] len_i,
    output logic          first_o,
    output logic          last_o,
    output logic          final_o
);

    localparam logic [CW-1:0] OFF_FIRST = CW'(2 * MCYC - MID);
    localparam logic [CW-1:0] OFF_LAST  = CW'(MCYC - MID);

    logic active;

    assign active  = (cnt_i != '0);
    assign first_o = active && (cnt_i == len_i - OFF_FIRST);
    assign last_o  = active && (cnt_i == len_i - OFF_LAST);
    assign final_o = active && (cnt_i == len_i);

endmodule

// File: rtl/subr_flow_unit.sv
module subr_flow_unit
    import subr_flow_pkg::*;
#(
    parameter logic [15:0] RST_PC = 16'h0000,
    parameter logic [15:0] RST_SP = 16'h0000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic [7:0]  opcode_i,
    input  logic [7:0]  imm_lo_i,
    input  logic [7:0]  imm_hi_i,
    input  logic [3:0]  flags_i,
    input  logic [7:0]  reg_h_i,
    input  logic [7:0]  reg_l_i,
    input  logic [7:0]  mem_rdata_i,
    output logic [15:0] mem_addr_o,
    output logic [7:0]  mem_wdata_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] pc_o,
    output logic [15:0] sp_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        flow_dec_t         dec;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] link;
        logic [BYTE_W-1:0] pop_lo;
        logic [BYTE_W-1:0] pop_hi;
    } flow_state_t;

    localparam flow_dec_t DEC_IDLE = '{
        kind: K_NONE, taken: 1'b0, len: '0, step: 2'd0, target: '0
    };
    localparam flow_state_t ST_RESET = '{
        cnt: '0, dec: DEC_IDLE, pc: RST_PC, sp: RST_SP,
        link: '0, pop_lo: '0, pop_hi: '0
    };

    flow_state_t st_d, st_q;
    flow_dec_t   dec_in;
    logic        slot_first, slot_last, slot_final;
    logic        push_act, pop_act;

    subr_op_decode u_dec (
        .opcode_i (opcode_i),
        .imm_lo_i (imm_lo_i),
        .imm_hi_i (imm_hi_i),
        .reg_h_i  (reg_h_i),
        .reg_l_i  (reg_l_i),
        .flags_i  (flags_i),
        .dec_o    (dec_in)
    );

    subr_slot_timer #(
        .CW   (CNT_W),
        .MCYC (MCYC_ST),
        .MID  (MID_ST)
    ) u_slot (
        .cnt_i   (st_q.cnt),
        .len_i   (st_q.dec.len),
        .first_o (slot_first),
        .last_o  (slot_last),
        .final_o (slot_final)
    );

    assign push_act = st_q.dec.taken &&
                      (st_q.dec.kind == K_CALL || st_q.dec.kind == K_RST);
    assign pop_act  = st_q.dec.taken && (st_q.dec.kind == K_RET);

    // memory strobes and addresses
    always_comb begin
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        if (push_act && slot_first) begin
            mem_addr_o  = st_q.sp - ADDR_W'(1);
            mem_wdata_o = st_q.link[ADDR_W-1:BYTE_W];
            mem_wr_o    = 1'b1;
        end else if (push_act && slot_last) begin
            mem_addr_o  = st_q.sp - ADDR_W'(2);
            mem_wdata_o = st_q.link[BYTE_W-1:0];
            mem_wr_o    = 1'b1;
        end else if (pop_act && slot_first) begin
            mem_addr_o  = st_q.sp;
            mem_rd_o    = 1'b1;
        end else if (pop_act && slot_last) begin
            mem_addr_o  = st_q.sp + ADDR_W'(1);
            mem_rd_o    = 1'b1;
        end
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            if (start_i && dec_in.kind != K_NONE) begin
                st_d.cnt  = CNT_W'(1);
                st_d.dec  = dec_in;
                st_d.link = st_q.pc + ADDR_W'(dec_in.step);
            end
        end else if (slot_final) begin
            st_d.cnt = '0;
            if (!st_q.dec.taken) begin
                st_d.pc = st_q.link;
            end else begin
                case (st_q.dec.kind)
                    K_CALL, K_RST: begin
                        st_d.pc = st_q.dec.target;
                        st_d.sp = st_q.sp - ADDR_W'(2);
                    end
                    K_RET: begin
                        st_d.pc = {st_q.pop_hi, st_q.pop_lo};
                        st_d.sp = st_q.sp + ADDR_W'(2);
                    end
                    K_JUMP:  st_d.pc = st_q.dec.target;
                    default: ;
                endcase
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (pop_act && slot_first) st_d.pop_lo = mem_rdata_i;
            if (pop_act && slot_last)  st_d.pop_hi = mem_rdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= ST_RESET;
        else         st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);
    assign done_o = slot_final;
    assign pc_o   = st_q.pc;
    assign sp_o   = st_q.sp;

    AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_o && mem_wr_o)); // R8
    AST_STROBE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_rd_o || mem_wr_o) |-> busy_o); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o && !busy_o); // R10
    AST_SP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |=> $stable(sp_o)); // R10
    AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |=> $stable(pc_o)); // R10
    AST_PUSH_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && push_act) |=> sp_o == $past(sp_o) - 16'd2); // R2
    AST_POP_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && pop_act) |=> sp_o == $past(sp_o) + 16'd2); // R4
    AST_UNKNOWN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && dec_in.kind == K_NONE) |=> !busy_o); // R1
    AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> busy_o); // R11

endmodule

// File: tb/subr_flow_unit_tb_top.sv
module subr_flow_unit_tb_top;

    localparam logic [15:0] P_PC = 16'h1000;
    localparam logic [15:0] P_SP = 16'h0003;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  opcode, imm_lo, imm_hi, reg_h, reg_l, mem_rdata, mem_wdata;
    logic [3:0]  flags;
    logic [15:0] mem_addr, pc, sp;
    logic        mem_rd, mem_wr, busy, done;

    always #5 clk = ~clk;

    subr_flow_unit #(.RST_PC(P_PC), .RST_SP(P_SP)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
        .imm_lo_i(imm_lo), .imm_hi_i(imm_hi), .flags_i(flags),
        .reg_h_i(reg_h), .reg_l_i(reg_l), .mem_rdata_i(mem_rdata),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rd_o(mem_rd),
        .mem_wr_o(mem_wr), .busy_o(busy), .done_o(done), .pc_o(pc), .sp_o(sp)
    );

    logic [7:0] phys [0:255];
    assign mem_rdata = phys[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) phys[mem_addr[7:0]] <= mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_pc, m_sp;
    logic [7:0]  m_mem [int];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit cond_true(input logic [2:0] c, input logic [3:0] f);
        case (c)
            3'd0: return !f[2];
            3'd1: return  f[2];
            3'd2: return !f[0];
            3'd3: return  f[0];
            3'd4: return !f[1];
            3'd5: return  f[1];
            3'd6: return !f[3];
            default: return f[3];
        endcase
    endfunction

    function automatic logic [7:0] mread(input logic [15:0] a);
        if (m_mem.exists(int'(a))) return m_mem[int'(a)];
        return 8'h00;
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [3:0] fl, input logic [7:0] h, input logic [7:0] l,
                          input bit poke, input string req);
        int L = 0;
        bit push = 0, pop = 0, taken = 0;
        logic [15:0] link, npc, nsp, a;
        logic [7:0] d;
        npc = m_pc; nsp = m_sp; link = m_pc;
        if (op == 8'hCD) begin
            taken = 1; L = 17; link = m_pc + 16'd3; push = 1; npc = {hi, lo};
        end else if (op[7:6] == 2'b11 && op[2:0] == 3'b100) begin
            taken = cond_true(op[5:3], fl); link = m_pc + 16'd3;
            L = taken ? 17 : 11; push = taken; npc = taken ? {hi, lo} : link;
        end else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin
            taken = 1; L = 11; link = m_pc + 16'd1; push = 1;
            npc = 16'(op[5:3]) * 16'd8;
        end else if (op == 8'hC9) begin
            taken = 1; L = 10; pop = 1;
        end else if (op[7:6] == 2'b11 && op[2:0] == 3'b000) begin
            taken = cond_true(op[5:3], fl); L = taken ? 11 : 5; pop = taken;
            npc = m_pc + 16'd1;
        end else if (op == 8'hE9) begin
            taken = 1; L = 5; npc = {h, l};
        end
        if (push) nsp = m_sp - 16'd2;
        if (pop) begin
            npc = {mread(m_sp + 16'd1), mread(m_sp)};
            nsp = m_sp + 16'd2;
        end
        opcode = op; imm_lo = lo; imm_hi = hi; flags = fl; reg_h = h; reg_l = l;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (L == 0) begin
            chk("R1", "busy after unknown opcode", int'(busy), 0);
            repeat (3) @(negedge clk);
            chk("R1", "pc after unknown opcode", int'(pc), int'(m_pc));
            chk("R1", "sp after unknown opcode", int'(sp), int'(m_sp));
            return;
        end
        for (int k = 1; k <= L; k++) begin
            bit ew, er;
            if (poke && k == 3) begin
                start = 1'b1; opcode = 8'hC9; flags = ~fl;
            end
            if (poke && k == 4) start = 1'b0;
            ew = push && (k == L - 4 || k == L - 1);
            er = pop  && (k == L - 4 || k == L - 1);
            chk("R7", "busy in window", int'(busy), 1);
            chk("R10", "done position", int'(done), int'(k == L));
            chk("R8", "write strobe", int'(mem_wr), int'(ew));
            chk("R8", "read strobe", int'(mem_rd), int'(er));
            if (ew) begin
                a = (k == L - 4) ? m_sp - 16'd1 : m_sp - 16'd2;
                d = (k == L - 4) ? link[15:8] : link[7:0];
                chk(req, "push address", int'(mem_addr), int'(a));
                chk(req, "push data", int'(mem_wdata), int'(d));
                m_mem[int'(a)] = d;
            end
            if (er) begin
                a = (k == L - 4) ? m_sp : m_sp + 16'd1;
                chk(req, "pop address", int'(mem_addr), int'(a));
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R7", "idle after final state", int'(busy), 0);
        chk(req, "pc result", int'(pc), int'(npc));
        chk(req, "sp result", int'(sp), int'(nsp));
        m_pc = npc; m_sp = nsp;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int fidx [4];
        fidx[0] = 2; fidx[1] = 0; fidx[2] = 1; fidx[3] = 3;
        for (int i = 0; i < 256; i++) phys[i] = 8'h00;
        rst_n = 1'b0; start = 1'b0; opcode = 8'h00; imm_lo = 8'h00; imm_hi = 8'h00;
        flags = 4'h0; reg_h = 8'h00; reg_l = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_pc = P_PC; m_sp = P_SP;
        chk("R10", "reset pc", int'(pc), int'(P_PC));
        chk("R10", "reset sp", int'(sp), int'(P_SP));
        chk("R8", "reset strobes", int'(mem_rd | mem_wr | busy | done), 0);

        // direct calls, second one wraps the stack through 0x0000 / 0xFFFF
        run_op(8'hCD, 8'h34, 8'h12, 4'h0, 8'h00, 8'h00, 0, "R2");
        run_op(8'hCD, 8'h00, 8'h20, 4'h0, 8'h00, 8'h00, 0, "R9");
        // returns pop back across the wrap
        run_op(8'hC9, 8'h00, 8'h00, 4'h0, 8'h00, 8'h00, 0, "R9");
        run_op(8'hC8, 8'h00, 8'h00, 4'h4, 8'h00, 8'h00, 0, "R4");
        run_op(8'hC0, 8'h00, 8'h00, 4'h4, 8'h00, 8'h00, 0, "R6");
        // pair jump
        run_op(8'hE9, 8'h00, 8'h00, 4'h0, 8'hAB, 8'hCD, 0, "R5");
        // restarts
        run_op(8'hFF, 8'h00, 8'h00, 4'h0, 8'h00, 8'h00, 0, "R3");
        run_op(8'hC7, 8'h00, 8'h00, 4'h0, 8'h00, 8'h00, 0, "R3");
        run_op(8'hD7, 8'h00, 8'h00, 4'h0, 8'h00, 8'h00, 0, "R3");
        // every condition with its flag set and cleared, others opposite
        for (int c = 0; c < 8; c++) begin
            for (int v = 0; v < 2; v++) begin
                logic [3:0] msk, fl;
                msk = 4'b0001 << fidx[c / 2];
                fl = v[0] ? msk : ~msk;
                run_op({2'b11, 3'(c), 3'b100}, 8'(8'h40 + c), 8'h30, fl, 8'h00, 8'h00, 0, "R6");
                run_op({2'b11, 3'(c), 3'b000}, 8'h00, 8'h00, ~fl, 8'h00, 8'h00, 0, "R6");
            end
        end
        // a second launch while busy must be ignored
        run_op(8'hCD, 8'h78, 8'h56, 4'h0, 8'h00, 8'h00, 1, "R11");
        run_op(8'hC9, 8'h00, 8'h00, 4'h0, 8'h00, 8'h00, 1, "R11");
        // opcodes outside the set
        run_op(8'h00, 8'h00, 8'h00, 4'h0, 8'h00, 8'h00, 0, "R1");
        run_op(8'hC3, 8'h11, 8'h22, 4'h0, 8'h00, 8'h00, 0, "R1");
        run_op(8'hCB, 8'h11, 8'h22, 4'hF, 8'h00, 8'h00, 0, "R1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule